// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This control unit sits beside the datapath of a small 16-bit processor. Each interrupt source raises a request line. Each source also presents a 3-bit priority level and an 8-bit vector. At every instruction boundary, which falls after the result store of one instruction and before the fetch of the next, the unit picks the most urgent pending source. It compares that source's level with the level held in the processor status word, PSR. If the request wins, the unit asserts `busy_o` and the normal fetch stalls. The unit then walks through a short save sequence. If the processor was in user mode, the sequence first swaps stacks. It then pushes PSR and PC onto the supervisor stack, switches the processor into supervisor mode at the new level, and loads PC from a vector table.

The unit also runs the return instruction. It pops PC, then pops PSR, and restores the user stack pointer when control goes back to user mode. If the return instruction is decoded while the processor is in user mode, it does not return. It enters a privilege exception instead. That exception uses a fixed internal vector and keeps the current level.

The unit does not hold the architectural registers itself. It reads PSR, PC, R6 and the saved user and supervisor stack pointers, and it drives a write strobe and a value for each register it changes. Memory is a single port with a combinational read.

States and transitions:
- IDLE goes to SWAP when an entry is taken from user mode. This covers a winning request and a return instruction decoded in user mode.
- IDLE goes to PUSH_PSR when an entry is taken from supervisor mode.
- IDLE goes to POP_PC when a return instruction is decoded in supervisor mode.
- SWAP goes to PUSH_PSR, PUSH_PSR goes to PUSH_PC, PUSH_PC goes to VECTOR, and VECTOR goes back to IDLE.
- POP_PC goes to POP_PSR. POP_PSR goes to USP_BACK when the popped word has bit 15 set, and to IDLE otherwise. USP_BACK goes to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: PSR bit 15 is the privilege bit (1 = user), bits [10:8] are the priority level and bits [2:0] are the condition codes. A request is taken at a boundary when its level is strictly greater than PSR[10:8].
- R2: A request whose level is equal to or lower than PSR[10:8] is not taken. `busy_o` stays low and PC is unchanged.
- R3: A sequence can start only in a cycle where `boundary_i` or `rti_i` is high. `busy_o` is high for the whole sequence: 4 cycles for an entry from user mode, 3 for an entry from supervisor mode, 3 for a return to user mode and 2 for a return to supervisor mode.
- R4: Among the active requests, the one with the highest level wins. Between equal levels, the lower request index wins.
- R5: An entry from user mode writes R6 to the saved user stack pointer and loads R6 from the saved supervisor stack pointer. An entry from supervisor mode leaves both unchanged.
- R6: A push first decrements R6 and then writes at the new R6. The old PSR is pushed first and PC second, so after the entry R6 equals the starting supervisor stack pointer minus 2.
- R7: After an entry, PSR[15] is 0, PSR[10:8] holds the winning level and PSR[2:0] is 0.
- R8: PC is loaded with the word at address 0x0100 plus the 8-bit vector.
- R9: A return reads PC from M[R6] and then PSR from M[R6+1]. R6 ends 2 higher.
- R10: If the popped PSR has bit 15 set, R6 is then reloaded from the saved user stack pointer. Otherwise R6 keeps its popped value.
- R11: A return instruction decoded in user mode takes the privilege exception. It runs a user-mode entry with vector 0x00 and keeps the current PSR level.
- R12: A request raised while a sequence runs does not change that sequence. It is taken at the next boundary if it is still raised then.
- R13: After reset the unit is idle. `busy_o` is low and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Instruction boundary, where an interrupt may be taken |
| rti_i | input | 1 | Return instruction decoded |
| irq_req_i | input | NREQ | Request lines |
| irq_lvl_i | input | NREQ*3 | Level of each request, packed by index |
| irq_vec_i | input | NREQ*8 | Vector of each request, packed by index |
| psr_i | input | 16 | Current PSR |
| pc_i | input | 16 | Current PC |
| r6_i | input | 16 | Current stack pointer R6 |
| usp_i | input | 16 | Saved user stack pointer |
| ssp_i | input | 16 | Saved supervisor stack pointer |
| busy_o | output | 1 | Sequence active; the fetch stalls while high |
| psr_we_o | output | 1 | PSR write strobe |
| psr_wd_o | output | 16 | PSR write value |
| pc_we_o | output | 1 | PC write strobe |
| pc_wd_o | output | 16 | PC write value |
| r6_we_o | output | 1 | R6 write strobe |
| r6_wd_o | output | 16 | R6 write value |
| usp_we_o | output | 1 | Saved user stack pointer write strobe |
| usp_wd_o | output | 16 | Saved user stack pointer write value |
| mem_addr_o | output | 16 | Memory address |
| mem_re_o | output | 1 | Memory read |
| mem_we_o | output | 1 | Memory write |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid in the same cycle as the address |

## Verification
Entries are started from user mode and from supervisor mode, so the stack swap can be told apart from a plain push. Each start is followed by a supervisor return and a user return, which separates keeping the popped R6 from reloading it from the saved user stack pointer. The request patterns cover these cases:
- an equal-level request, which must not be taken;
- mixed levels with a tie at the top, which tests level ordering and index ordering together;
- requests held while `boundary_i` is low;
- a higher request raised in the middle of a sequence, which must wait for the next boundary.

A return decoded in user mode checks that the exception keeps the current level and takes its vector from inside the unit.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PSR_PRIV_BIT = 15;
    localparam int PSR_LVL_LO   = 8;
    localparam int PSR_CC_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWAP,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VECTOR,
        ST_POP_PC,
        ST_POP_PSR,
        ST_USP_BACK
    } seq_state_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NREQ = 4,
    parameter int LVLW = 3,
    parameter int VECW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_i,
    input  logic [NREQ*LVLW-1:0]   lvl_i,
    input  logic [NREQ*VECW-1:0]   vec_i,
    output logic                   valid_o,
    output logic [LVLW-1:0]        lvl_o,
    output logic [VECW-1:0]        vec_o
);

    logic [LVLW-1:0] lvl_a [NREQ];
    logic [VECW-1:0] vec_a [NREQ];

    for (genvar g = 0; g < NREQ; g++) begin : g_unpack
        assign lvl_a[g] = lvl_i[g*LVLW +: LVLW];
        assign vec_a[g] = vec_i[g*VECW +: VECW];

        // No active request may outrank the chosen one
        AST_PICK_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[g] |-> (valid_o && lvl_a[g] <= lvl_o)); // R4
    end

    // Ascending scan; a later index replaces only on a strictly higher level,
    // so the lower index keeps a tie.
    always_comb begin
        valid_o = 1'b0;
        lvl_o   = '0;
        vec_o   = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req_i[i] && (!valid_o || lvl_a[i] > lvl_o)) begin
                valid_o = 1'b1;
                lvl_o   = lvl_a[i];
                vec_o   = vec_a[i];
            end
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
#(
    parameter int            DW       = 16,
    parameter int            LVLW     = 3,
    parameter int            VECW     = 8,
    parameter logic [DW-1:0] VEC_BASE = 16'h0100,
    parameter logic [VECW-1:0] EXC_VEC = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary_i,
    input  logic            rti_i,
    input  logic            pick_valid_i,
    input  logic [LVLW-1:0] pick_lvl_i,
    input  logic [VECW-1:0] pick_vec_i,
    input  logic [DW-1:0]   psr_i,
    input  logic [DW-1:0]   pc_i,
    input  logic [DW-1:0]   r6_i,
    input  logic [DW-1:0]   usp_i,
    input  logic [DW-1:0]   ssp_i,
    output logic            busy_o,
    output logic            psr_we_o,
    output logic [DW-1:0]   psr_wd_o,
    output logic            pc_we_o,
    output logic [DW-1:0]   pc_wd_o,
    output logic            r6_we_o,
    output logic [DW-1:0]   r6_wd_o,
    output logic            usp_we_o,
    output logic [DW-1:0]   usp_wd_o,
    output logic [DW-1:0]   mem_addr_o,
    output logic            mem_re_o,
    output logic            mem_we_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i
);

    localparam int TBL_SPAN = 1 << VECW;

    seq_state_e      state_q, state_d;
    logic [LVLW-1:0] lvl_q, lvl_d;
    logic [VECW-1:0] vec_q, vec_d;
    logic [LVLW-1:0] cur_lvl;
    logic            is_user;
    logic            wins;

    assign cur_lvl = psr_i[PSR_LVL_LO +: LVLW];
    assign is_user = psr_i[PSR_PRIV_BIT];
    assign wins    = pick_valid_i && (pick_lvl_i > cur_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            vec_q   <= vec_d;
        end
    end

    // Next state and captured entry parameters
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        vec_d   = vec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rti_i) begin
                    if (is_user) begin
                        lvl_d   = cur_lvl;
                        vec_d   = EXC_VEC;
                        state_d = ST_SWAP;
                    end else begin
                        state_d = ST_POP_PC;
                    end
                end else if (boundary_i && wins) begin
                    lvl_d   = pick_lvl_i;
                    vec_d   = pick_vec_i;
                    state_d = is_user ? ST_SWAP : ST_PUSH_PSR;
                end
            end
            ST_SWAP:     state_d = ST_PUSH_PSR;
            ST_PUSH_PSR: state_d = ST_PUSH_PC;
            ST_PUSH_PC:  state_d = ST_VECTOR;
            ST_VECTOR:   state_d = ST_IDLE;
            ST_POP_PC:   state_d = ST_POP_PSR;
            ST_POP_PSR:  state_d = mem_rdata_i[PSR_PRIV_BIT] ? ST_USP_BACK : ST_IDLE;
            ST_USP_BACK: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        psr_we_o    = 1'b0;
        psr_wd_o    = psr_i;
        pc_we_o     = 1'b0;
        pc_wd_o     = mem_rdata_i;
        r6_we_o     = 1'b0;
        r6_wd_o     = r6_i;
        usp_we_o    = 1'b0;
        usp_wd_o    = r6_i;
        mem_addr_o  = r6_i;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = psr_i;
        unique case (state_q)
            ST_IDLE: ;
            ST_SWAP: begin
                usp_we_o = 1'b1;
                r6_we_o  = 1'b1;
                r6_wd_o  = ssp_i;
            end
            ST_PUSH_PSR, ST_PUSH_PC: begin
                r6_we_o     = 1'b1;
                r6_wd_o     = r6_i - 1'b1;
                mem_addr_o  = r6_i - 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = (state_q == ST_PUSH_PSR) ? psr_i : pc_i;
            end
            ST_VECTOR: begin
                mem_addr_o = VEC_BASE + DW'(vec_q);
                mem_re_o   = 1'b1;
                pc_we_o    = 1'b1;
                psr_we_o   = 1'b1;
                psr_wd_o[PSR_PRIV_BIT]          = 1'b0;
                psr_wd_o[PSR_LVL_LO +: LVLW]    = lvl_q;
                psr_wd_o[PSR_CC_W-1:0]          = '0;
            end
            ST_POP_PC: begin
                mem_re_o = 1'b1;
                pc_we_o  = 1'b1;
                r6_we_o  = 1'b1;
                r6_wd_o  = r6_i + 1'b1;
            end
            ST_POP_PSR: begin
                mem_re_o = 1'b1;
                psr_we_o = 1'b1;
                psr_wd_o = mem_rdata_i;
                r6_we_o  = 1'b1;
                r6_wd_o  = r6_i + 1'b1;
            end
            ST_USP_BACK: begin
                r6_we_o = 1'b1;
                r6_wd_o = usp_i;
            end
            default: ;
        endcase
    end

    AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rti_i && !(pick_valid_i && pick_lvl_i > cur_lvl))
        |=> !busy_o); // R2
    AST_START_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(boundary_i || rti_i)); // R3
    AST_WRITE_IN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (state_q == ST_PUSH_PSR || state_q == ST_PUSH_PC)); // R6
    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (r6_we_o && mem_addr_o == r6_wd_o)); // R6
    AST_VEC_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VECTOR) |-> (mem_re_o && pc_we_o && mem_addr_o >= VEC_BASE
                                    && mem_addr_o < VEC_BASE + TBL_SPAN)); // R8
    AST_SUPV_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VECTOR) |=> !psr_i[PSR_PRIV_BIT]); // R7
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re_o, mem_we_o})); // R9

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int NREQ = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              rti_i,
    input  logic [NREQ-1:0]   irq_req_i,
    input  logic [NREQ*3-1:0] irq_lvl_i,
    input  logic [NREQ*8-1:0] irq_vec_i,
    input  logic [15:0]       psr_i,
    input  logic [15:0]       pc_i,
    input  logic [15:0]       r6_i,
    input  logic [15:0]       usp_i,
    input  logic [15:0]       ssp_i,
    output logic              busy_o,
    output logic              psr_we_o,
    output logic [15:0]       psr_wd_o,
    output logic              pc_we_o,
    output logic [15:0]       pc_wd_o,
    output logic              r6_we_o,
    output logic [15:0]       r6_wd_o,
    output logic              usp_we_o,
    output logic [15:0]       usp_wd_o,
    output logic [15:0]       mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [15:0]       mem_wdata_o,
    input  logic [15:0]       mem_rdata_i
);

    localparam int LVLW = 3;
    localparam int VECW = 8;

    logic            pick_valid;
    logic [LVLW-1:0] pick_lvl;
    logic [VECW-1:0] pick_vec;

    irq_prio_pick #(.NREQ(NREQ), .LVLW(LVLW), .VECW(VECW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (irq_req_i),
        .lvl_i   (irq_lvl_i),
        .vec_i   (irq_vec_i),
        .valid_o (pick_valid),
        .lvl_o   (pick_lvl),
        .vec_o   (pick_vec)
    );

    irq_seq_fsm #(.DW(16), .LVLW(LVLW), .VECW(VECW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary_i   (boundary_i),
        .rti_i        (rti_i),
        .pick_valid_i (pick_valid),
        .pick_lvl_i   (pick_lvl),
        .pick_vec_i   (pick_vec),
        .psr_i        (psr_i),
        .pc_i         (pc_i),
        .r6_i         (r6_i),
        .usp_i        (usp_i),
        .ssp_i        (ssp_i),
        .busy_o       (busy_o),
        .psr_we_o     (psr_we_o),
        .psr_wd_o     (psr_wd_o),
        .pc_we_o      (pc_we_o),
        .pc_wd_o      (pc_wd_o),
        .r6_we_o      (r6_we_o),
        .r6_wd_o      (r6_wd_o),
        .usp_we_o     (usp_we_o),
        .usp_wd_o     (usp_wd_o),
        .mem_addr_o   (mem_addr_o),
        .mem_re_o     (mem_re_o),
        .mem_we_o     (mem_we_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i)
    );

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_we_o); // R13

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ       = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              boundary = 1'b0;
    logic              rti = 1'b0;
    logic [NREQ-1:0]   irq_req = '0;
    logic [NREQ*3-1:0] irq_lvl = '0;
    logic [NREQ*8-1:0] irq_vec = '0;
    logic [15:0]       psr_r, pc_r, r6_r, usp_r, ssp_r;
    logic              busy, psr_we, pc_we, r6_we, usp_we, mem_re, mem_we;
    logic [15:0]       psr_wd, pc_wd, r6_wd, usp_wd, mem_addr, mem_wdata, mem_rdata;
    logic [15:0]       mem [1024];

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq #(.NREQ(NREQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .rti_i(rti),
        .irq_req_i(irq_req), .irq_lvl_i(irq_lvl), .irq_vec_i(irq_vec),
        .psr_i(psr_r), .pc_i(pc_r), .r6_i(r6_r), .usp_i(usp_r), .ssp_i(ssp_r),
        .busy_o(busy), .psr_we_o(psr_we), .psr_wd_o(psr_wd), .pc_we_o(pc_we),
        .pc_wd_o(pc_wd), .r6_we_o(r6_we), .r6_wd_o(r6_wd), .usp_we_o(usp_we),
        .usp_wd_o(usp_wd), .mem_addr_o(mem_addr), .mem_re_o(mem_re),
        .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // Datapath and memory stand-in
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (psr_we) psr_r <= psr_wd;
        if (pc_we)  pc_r  <= pc_wd;
        if (r6_we)  r6_r  <= r6_wd;
        if (usp_we) usp_r <= usp_wd;
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every memory write must match the next expected push
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6: unexpected write actual %h:%h expected none", mem_addr, mem_wdata);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    n_bad++;
                    $display("FAIL R6: push actual %h expected %h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic expect_push(input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic set_state(input logic [15:0] psr, input logic [15:0] pc,
                             input logic [15:0] r6, input logic [15:0] usp);
        @(negedge clk);
        psr_r = psr; pc_r = pc; r6_r = r6; usp_r = usp;
    endtask

    task automatic set_req(input int idx, input logic on, input logic [2:0] lvl, input logic [7:0] vec);
        irq_req[idx]       = on;
        irq_lvl[idx*3 +: 3] = lvl;
        irq_vec[idx*8 +: 8] = vec;
    endtask

    // Pulse boundary or return; returns busy cycle count
    task automatic pulse(input logic is_rti, output int cycles);
        @(negedge clk);
        if (is_rti) rti = 1'b1; else boundary = 1'b1;
        @(negedge clk);
        rti = 1'b0; boundary = 1'b0;
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        mem[10'h180] = 16'h6200;
        mem[10'h181] = 16'h6300;
        mem[10'h182] = 16'h5000;
        mem[10'h183] = 16'h5100;
        mem[10'h100] = 16'h1000;
        psr_r = 16'h8002; pc_r = 16'h3006; r6_r = 16'h3FF0; usp_r = 16'h0000; ssp_r = 16'h0300;
        repeat (3) @(negedge clk);
        check("R13 busy in reset", {15'b0, busy}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 busy after reset", {15'b0, busy}, 16'h0);
        check("R13 no write after reset", {15'b0, mem_we}, 16'h0);

        // User-mode entry, level 4 beats level 0, vector 0x80
        set_req(1, 1'b1, 3'd4, 8'h80);
        expect_push(16'h02FF, 16'h8002);
        expect_push(16'h02FE, 16'h3006);
        pulse(1'b0, cyc);
        check("R3 user entry busy cycles", 16'(cyc), 16'd4);
        check("R5 saved USP", usp_r, 16'h3FF0);
        check("R6 R6 after entry", r6_r, 16'h02FE);
        check("R1 R7 PSR after entry", psr_r, 16'h0400);
        check("R8 PC from vector table", pc_r, 16'h6200);
        set_req(1, 1'b0, 3'd0, 8'h00);

        // Equal level not taken
        pc_r = 16'h6203;
        set_req(2, 1'b1, 3'd4, 8'h81);
        pulse(1'b0, cyc);
        check("R2 equal level busy", 16'(cyc), 16'd0);
        check("R2 equal level PC", pc_r, 16'h6203);

        // Mixed levels with a tie at the top: index 2 wins over 3 and 0
        set_req(2, 1'b1, 3'd6, 8'h81);
        set_req(3, 1'b1, 3'd6, 8'h83);
        set_req(0, 1'b1, 3'd5, 8'h82);
        expect_push(16'h02FD, 16'h0400);
        expect_push(16'h02FC, 16'h6203);
        pulse(1'b0, cyc);
        check("R3 supervisor entry busy cycles", 16'(cyc), 16'd3);
        check("R4 tie and level pick PC", pc_r, 16'h6300);
        check("R7 nested PSR", psr_r, 16'h0600);
        check("R5 USP untouched in supervisor", usp_r, 16'h3FF0);
        check("R6 R6 nested", r6_r, 16'h02FC);
        irq_req = '0;

        // Return to supervisor
        pulse(1'b1, cyc);
        check("R3 return to supervisor cycles", 16'(cyc), 16'd2);
        check("R9 popped PC", pc_r, 16'h6203);
        check("R9 popped PSR", psr_r, 16'h0400);
        check("R10 R6 kept", r6_r, 16'h02FE);

        // Return to user
        pulse(1'b1, cyc);
        check("R3 return to user cycles", 16'(cyc), 16'd3);
        check("R9 popped PC user", pc_r, 16'h3006);
        check("R9 popped PSR user", psr_r, 16'h8002);
        check("R10 R6 from USP", r6_r, 16'h3FF0);

        // Return decoded in user mode: privilege exception
        set_state(16'h8302, 16'h3010, 16'h3F00, 16'h3FF0);
        expect_push(16'h02FF, 16'h8302);
        expect_push(16'h02FE, 16'h3010);
        pulse(1'b1, cyc);
        check("R11 exception busy cycles", 16'(cyc), 16'd4);
        check("R11 exception PC", pc_r, 16'h1000);
        check("R11 exception PSR keeps level", psr_r, 16'h0300);
        check("R11 exception USP", usp_r, 16'h3F00);

        // Requests held without boundary
        set_state(16'h0000, 16'h4000, 16'h0300, 16'h3F00);
        set_req(0, 1'b1, 3'd5, 8'h82);
        repeat (3) @(negedge clk);
        check("R3 no boundary busy", {15'b0, busy}, 16'h0);
        check("R3 no boundary PC", pc_r, 16'h4000);

        // Higher request arrives mid-sequence
        set_req(0, 1'b1, 3'd2, 8'h82);
        expect_push(16'h02FF, 16'h0000);
        expect_push(16'h02FE, 16'h4000);
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        set_req(3, 1'b1, 3'd7, 8'h83);
        while (busy) @(negedge clk);
        check("R12 running entry unchanged PC", pc_r, 16'h5000);
        check("R12 running entry level", psr_r, 16'h0200);
        expect_push(16'h02FD, 16'h0200);
        expect_push(16'h02FC, 16'h5000);
        pulse(1'b0, cyc);
        check("R12 held request taken PC", pc_r, 16'h5100);
        check("R12 held request PSR", psr_r, 16'h0700);
        irq_req = '0;

        check("R6 all pushes seen", 16'(exp_q.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule